// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation converter. It watches an active-low chip select and a read/convert strobe. When the two are combined by an OR and that OR falls, the block holds the sampled input and starts a conversion. It then walks the result bits from the most significant bit down. For each bit it places a trial code on a DAC bus and keeps or clears the bit according to a one-bit comparator input.

When the last bit is settled, the block writes the code to a result register and releases its busy flag. The code is written as straight binary or with the top bit inverted, which gives two's complement. If the start condition is still present at the moment busy returns high, the next conversion starts at once. A power-down input stops new conversions from starting and leaves the last result in place.

The sample/hold, DAC and comparator are outside the block and are seen only through ports. All inputs are taken to be synchronous to `clk`.

Top module: `sar_seq`

## Requirements
- R1: A conversion starts when the block is idle, `pwr_dn` is low, and `cs_n | rd_conv` goes from 1 to 0 between two rising edges. At the edge that samples the 0, `busy` goes low and `hold` goes high. With `cs_n` high, pulses on `rd_conv` start nothing.
- R2: `busy` stays low for exactly NBITS*TRIAL_CYC clock cycles per conversion. `hold` is always the inverse of `busy`.
- R3: Trials run from the MSB down, and the first trial code on `dac_code` is 1<<(NBITS-1). A bit is kept when `cmp_hi` is 1 at the end of its trial, where 1 means the analog input is at or above the DAC level. In straight-binary form the result equals the input code.
- R4: `fmt_sb` is sampled when the result is latched. A 1 stores straight binary. A 0 stores the same code with bit NBITS-1 inverted, which is two's complement.
- R5: If `cs_n` and `rd_conv` are both low in the first clock cycle after `busy` rises, a new conversion starts at once, with no new falling edge needed.
- R6: While `pwr_dn` is high and the block is idle, start conditions are ignored, `busy` stays high and `result` is unchanged. A falling edge seen during power-down is not kept for later.
- R7: Start edges that arrive while `busy` is low are ignored, as long as the start condition is gone again by the time the conversion completes.
- R8: Reset puts the block in idle, with `busy`=1, `hold`=0, `result`=0 and `dac_code`=0.
- R9: `result` changes only at the clock edge where `busy` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read/convert strobe, falling edge starts |
| pwr_dn | input | 1 | Power-down, blocks new conversions |
| fmt_sb | input | 1 | 1 = straight binary, 0 = two's complement |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| hold | output | 1 | Hold command to the sample/hold |
| busy | output | 1 | Low while a conversion runs |
| dac_code | output | NBITS | Trial code for the DAC |
| result | output | NBITS | Latched conversion result |

## Verification
The bench builds the block with NBITS=16 and TRIAL_CYC=2, so each conversion keeps `busy` low for 32 cycles. At that length the exact busy-low count, the automatic restart and edges injected mid-conversion can all be checked against a cycle count within a short run. The comparator is modelled as the full 16-bit input code compared with `dac_code`. This exposes every bit decision, the all-zeros and all-ones codes, and the mid-scale inversion in both output formats.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS     = 16,
  parameter int TRIAL_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_conv,
  input  logic             pwr_dn,
  input  logic             fmt_sb,
  input  logic             cmp_hi,
  output logic             hold,
  output logic             busy,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result
);
  localparam int CW = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [NBITS-1:0] MSB = {1'b1, {(NBITS-1){1'b0}}};

  logic          active, req_q, done_q;
  logic [CW-1:0] cyc;
  logic [BW-1:0] bitpos;
  logic [NBITS-1:0] one_hot, decided;

  wire req       = ~(cs_n | rd_conv);
  wire go        = ~active & ~pwr_dn & req & (~req_q | done_q);
  wire trial_end = (cyc == CW'(TRIAL_CYC - 1));
  wire last      = trial_end && (bitpos == '0);

  assign one_hot = NBITS'(1) << bitpos;
  assign decided = cmp_hi ? dac_code : (dac_code & ~one_hot);
  assign busy    = ~active;
  assign hold    = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      cyc      <= '0;
      bitpos   <= '0;
      dac_code <= '0;
      result   <= '0;
    end else begin
      req_q  <= req;
      done_q <= active & last;
      if (go) begin
        active   <= 1'b1;
        cyc      <= '0;
        bitpos   <= BW'(NBITS - 1);
        dac_code <= MSB;
      end else if (active) begin
        if (trial_end) begin
          cyc <= '0;
          if (last) begin
            active   <= 1'b0;
            dac_code <= decided;
            result   <= fmt_sb ? decided : (decided ^ MSB);
          end else begin
            bitpos   <= bitpos - 1'b1;
            dac_code <= decided | (one_hot >> 1);
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS     = 16,
  parameter int TRIAL_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_conv,
  input logic             pwr_dn,
  input logic             hold,
  input logic             busy,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-1:0] result
);
  localparam int LEN = NBITS * TRIAL_CYC;
  localparam int LW  = $clog2(LEN + 1) + 1;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= '0;
    else if (busy) low_cnt <= '0;
    else           low_cnt <= low_cnt + 1'b1;
  end

  a_r1_start_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!$past(cs_n) && !$past(rd_conv) && !$past(pwr_dn)));

  a_r2_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (low_cnt == LW'(LEN)));

  a_r2_hold_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    hold != busy);

  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (dac_code == {1'b1, {(NBITS-1){1'b0}}}));

  a_r6_pwrdn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwr_dn) |=> busy);

  a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(result));
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS), .TRIAL_CYC(TRIAL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .pwr_dn(pwr_dn),
  .hold(hold), .busy(busy), .dac_code(dac_code), .result(result)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int N = 16;
  localparam int T = 2;
  localparam int LEN = N * T;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, rd_conv = 1'b1, pwr_dn = 1'b0, fmt_sb = 1'b1;
  logic [N-1:0] vin = '0;
  logic hold, busy, cmp_hi;
  logic [N-1:0] dac_code, result;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign cmp_hi = (vin >= dac_code);

  sar_seq #(.NBITS(N), .TRIAL_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .pwr_dn(pwr_dn),
    .fmt_sb(fmt_sb), .cmp_hi(cmp_hi), .hold(hold), .busy(busy),
    .dac_code(dac_code), .result(result));

  localparam logic [N:0] VEC [8] = '{
    {1'b1, 16'h0000}, {1'b1, 16'hFFFF}, {1'b1, 16'h8000}, {1'b1, 16'h7FFF},
    {1'b0, 16'h1234}, {1'b0, 16'hA5A5}, {1'b0, 16'h0000}, {1'b1, 16'h5A3C}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_conv(output int lowcnt);
    @(negedge clk) rd_conv = 1'b0;
    @(negedge clk);
    lowcnt = 0;
    while (busy == 1'b0 && lowcnt < 1000) begin
      lowcnt++;
      rd_conv = 1'b1;
      @(negedge clk);
    end
  endtask

  function automatic logic [N-1:0] fmt(input logic sb, input logic [N-1:0] v);
    return sb ? v : (v ^ 16'h8000);
  endfunction

  initial begin
    int lc;
    logic [N-1:0] keep;
    repeat (3) @(negedge clk);
    chk(busy == 1 && hold == 0, "R8 idle outputs", {busy, hold}, 2'b10);
    chk(result == 0 && dac_code == 0, "R8 cleared regs", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      fmt_sb = VEC[i][N];
      vin = VEC[i][N-1:0];
      run_conv(lc);
      chk(lc == LEN, "R2 busy length", lc, LEN);
      chk(result == fmt(fmt_sb, vin), "R3/R4 vector result", result, fmt(fmt_sb, vin));
      repeat (2) @(negedge clk);
    end

    fmt_sb = 1'b1; vin = 16'h3C3C;
    @(negedge clk) rd_conv = 1'b0;
    @(negedge clk);
    chk(dac_code == 16'h8000, "R3 first trial MSB", dac_code, 16'h8000);
    chk(busy == 0 && hold == 1, "R1 start hold", {busy, hold}, 2'b01);
    rd_conv = 1'b1;
    while (!busy) @(negedge clk);
    chk(result == 16'h3C3C, "R3 directed result", result, 16'h3C3C);

    cs_n = 1'b1;
    @(negedge clk) rd_conv = 1'b0;
    @(negedge clk) rd_conv = 1'b1;
    lc = 0;
    repeat (6) begin @(negedge clk); if (!busy) lc++; end
    chk(lc == 0, "R1 cs_n high blocks", lc, 0);
    rd_conv = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 cs_n fall starts", busy, 0);
    rd_conv = 1'b1;
    while (!busy) @(negedge clk);

    keep = result;
    pwr_dn = 1'b1; vin = 16'h1111;
    @(negedge clk) rd_conv = 1'b0;
    @(negedge clk) rd_conv = 1'b1;
    lc = 0;
    repeat (8) begin @(negedge clk); if (!busy) lc++; end
    chk(lc == 0, "R6 no start in power-down", lc, 0);
    chk(result == keep, "R6 result kept", result, keep);
    rd_conv = 1'b0;
    @(negedge clk) pwr_dn = 1'b0;
    lc = 0;
    repeat (6) begin @(negedge clk); if (!busy) lc++; end
    chk(lc == 0, "R6 edge not remembered", lc, 0);
    rd_conv = 1'b1;
    @(negedge clk);

    vin = 16'hC001; fmt_sb = 1'b0;
    @(negedge clk) rd_conv = 1'b0;
    @(negedge clk) rd_conv = 1'b1;
    repeat (5) @(negedge clk);
    rd_conv = 1'b0;
    @(negedge clk) rd_conv = 1'b1;
    while (!busy) @(negedge clk);
    lc = 0;
    repeat (20) begin @(negedge clk); if (!busy) lc++; end
    chk(lc == 0, "R7 mid edge ignored", lc, 0);
    chk(result == 16'h4001, "R7 R4 result", result, 16'h4001);

    fmt_sb = 1'b1; vin = 16'h0F0F;
    @(negedge clk) rd_conv = 1'b0;
    @(negedge clk);
    while (!busy) @(negedge clk);
    chk(result == 16'h0F0F, "R5 first result", result, 16'h0F0F);
    vin = 16'hBEEF;
    @(negedge clk);
    chk(busy == 0, "R5 auto restart", busy, 0);
    rd_conv = 1'b1;
    lc = 1;
    @(negedge clk);
    while (!busy && lc < 1000) begin lc++; @(negedge clk); end
    chk(lc == LEN, "R5 R2 restart length", lc, LEN);
    chk(result == 16'hBEEF, "R5 second result", result, 16'hBEEF);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule